// File: doc/BRIEF.md
# Trace Memory Software Access Port

This block holds a 256-entry trace memory, 64 bits per entry, and lets software reach any entry through a small 32-bit register port. Software places an index and a one-shot command in a control register. A read command copies the selected entry into two 32-bit staging registers, the upper half and the lower half. A write command stores the contents of those two staging registers into the selected entry. Both command bits return to zero by themselves once the command has run.

The memory also has a capture input. While software holds the block in the active state, every cycle with capture-valid high stores the capture word at a capture pointer, and the pointer then advances, wrapping at 256. Software writes are not allowed to disturb a running capture, so they are dropped while the block is active. Software reads are still allowed and give a consistent view of the memory.

Top module: `trace_buf_port`

## Requirements
- R1: After reset, the control, upper data, lower data and status registers all read as zero, and the capture pointer is 0.
- R2: The register port accepts every access in the cycle it is presented (ready is held high). The byte offsets are: control 0x60, upper data 0x64, lower data 0x68, status 0x6C. Any other offset reads as zero and ignores writes.
- R3: Writing control with bit 8 set (read command) and an index in bits 7:0 loads the upper data register with entry bits 63:32 and the lower data register with bits 31:0 on the next clock edge. Bit 8 then reads back as 0.
- R4: Writing control with bit 9 set (write command) while the block is inactive stores {upper, lower} into the indexed entry on the next clock edge. Bit 9 then reads back as 0.
- R5: A write command issued while the block is active leaves the entry unchanged, and bit 9 still clears.
- R6: When bits 8 and 9 are written as 1 together, only the read is performed. The entry is not written, and both bits clear.
- R7: While status bit 0 (active) is 1, each cycle with cap_valid high stores cap_data at the capture pointer, and the pointer advances by one modulo 256. Status bits 15:8 show the pointer.
- R8: Read commands work while the block is active and return the captured contents.
- R9: The index field in control bits 7:0 holds its value after a command and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access present |
| reg_write | input | 1 | 1 = write access, 0 = read access |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Access accepted (always high) |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cap_valid | input | 1 | Capture word present |
| cap_data | input | 64 | Capture word |

## Verification
The bench writes a distinct pattern to all 256 entries through the staging registers and reads every entry back. A half swap or an off-by-one index would show up as a mismatch on almost every entry. It then captures 300 words, so the pointer wraps. A pointer that does not wrap, or one that advances without cap_valid, leaves the wrong entries holding the newer words and shows the wrong status value. While the block is active, a software write to an entry that the bench has already read must not change that entry, and a block that lets it through would return the staged value on the next read. A combined read-and-write command must return the old entry and must not overwrite it with the staged data. A command bit that fails to clear shows up when the control register is read back.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h60;
  localparam logic [7:0] OFF_HI   = 8'h64;
  localparam logic [7:0] OFF_LO   = 8'h68;
  localparam logic [7:0] OFF_STAT = 8'h6C;
  localparam int CTRL_RD_BIT  = 8;
  localparam int CTRL_WR_BIT  = 9;
  localparam int STAT_ACT_BIT = 0;
  localparam int STAT_PTR_LSB = 8;
endpackage

// File: rtl/tbp_mem.sv
module tbp_mem #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/tbp_capture.sv
module tbp_capture #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [IDX_W-1:0]  ptr
);
  logic             cap_go;
  logic [IDX_W-1:0] ptr_n;

  assign cap_go = active & cap_valid;

  always_comb begin
    ptr_n = ptr;
    if (cap_go) ptr_n = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (cap_go) ptr <= ptr_n;
  end

  // the single write port goes to capture first; software writes never
  // coincide because they are only issued while inactive
  always_comb begin
    mem_we    = cap_go | sw_we;
    mem_waddr = cap_go ? ptr      : sw_idx;
    mem_wdata = cap_go ? cap_data : sw_wdata;
  end
endmodule

// File: rtl/tbp_regs.sv
module tbp_regs
  import tbp_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_valid,
  input  logic                 reg_write,
  input  logic [7:0]           reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [2*REG_W-1:0]   mem_rdata,
  input  logic [IDX_W-1:0]     cap_ptr,
  output logic [IDX_W-1:0]     sel_idx,
  output logic                 sw_we,
  output logic [2*REG_W-1:0]   sw_wdata,
  output logic                 active
);
  logic             wr_acc;
  logic             wr_ctrl, wr_hi, wr_lo, wr_stat;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             rd_q, rd_n, wrc_q, wrc_n;
  logic [REG_W-1:0] hi_q, hi_n, lo_q, lo_n;
  logic             act_n;
  logic             do_rd;
  logic             hi_en, lo_en;
  logic [REG_W-1:0] ctrl_word, stat_word;

  assign wr_acc  = reg_valid & reg_write;
  assign wr_ctrl = wr_acc & (reg_addr == OFF_CTRL);
  assign wr_hi   = wr_acc & (reg_addr == OFF_HI);
  assign wr_lo   = wr_acc & (reg_addr == OFF_LO);
  assign wr_stat = wr_acc & (reg_addr == OFF_STAT);

  // a pending command runs in the cycle after it was written; read wins
  assign do_rd = rd_q;
  assign sw_we = wrc_q & ~rd_q & ~active;

  always_comb begin
    idx_n = idx_q;
    rd_n  = 1'b0;
    wrc_n = 1'b0;
    if (wr_ctrl) begin
      idx_n = reg_wdata[IDX_W-1:0];
      rd_n  = reg_wdata[CTRL_RD_BIT];
      wrc_n = reg_wdata[CTRL_WR_BIT];
    end
  end

  always_comb begin
    hi_en = do_rd | wr_hi;
    lo_en = do_rd | wr_lo;
    hi_n  = do_rd ? mem_rdata[2*REG_W-1:REG_W] : reg_wdata;
    lo_n  = do_rd ? mem_rdata[REG_W-1:0]       : reg_wdata;
    act_n = wr_stat ? reg_wdata[STAT_ACT_BIT] : active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      rd_q   <= 1'b0;
      wrc_q  <= 1'b0;
      hi_q   <= '0;
      lo_q   <= '0;
      active <= 1'b0;
    end else begin
      idx_q  <= idx_n;
      rd_q   <= rd_n;
      wrc_q  <= wrc_n;
      if (hi_en) hi_q <= hi_n;
      if (lo_en) lo_q <= lo_n;
      active <= act_n;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[IDX_W-1:0]   = idx_q;
    ctrl_word[CTRL_RD_BIT] = rd_q;
    ctrl_word[CTRL_WR_BIT] = wrc_q;
    stat_word = '0;
    stat_word[STAT_ACT_BIT] = active;
    stat_word[STAT_PTR_LSB +: IDX_W] = cap_ptr;
  end

  always_comb begin
    case (reg_addr)
      OFF_CTRL: reg_rdata = ctrl_word;
      OFF_HI:   reg_rdata = hi_q;
      OFF_LO:   reg_rdata = lo_q;
      OFF_STAT: reg_rdata = stat_word;
      default:  reg_rdata = '0;
    endcase
  end

  assign sel_idx  = idx_q;
  assign sw_wdata = {hi_q, lo_q};
endmodule

// File: rtl/trace_buf_port.sv
module trace_buf_port #(
  parameter int IDX_W = 8,
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_valid,
  input  logic               reg_write,
  input  logic [7:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic               reg_ready,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               cap_valid,
  input  logic [2*REG_W-1:0] cap_data
);
  localparam int DATA_W = 2 * REG_W;

  logic [IDX_W-1:0]  sel_idx;
  logic              sw_we;
  logic [DATA_W-1:0] sw_wdata;
  logic              active;
  logic [IDX_W-1:0]  cap_ptr;
  logic              mem_we;
  logic [IDX_W-1:0]  mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;

  assign reg_ready = 1'b1;

  tbp_regs #(.IDX_W(IDX_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rdata(mem_rdata), .cap_ptr(cap_ptr),
    .sel_idx(sel_idx), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .active(active)
  );

  tbp_capture #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst_n(rst_n),
    .active(active), .cap_valid(cap_valid), .cap_data(cap_data),
    .sw_we(sw_we), .sw_idx(sel_idx), .sw_wdata(sw_wdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .ptr(cap_ptr)
  );

  tbp_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(sel_idx), .rdata(mem_rdata)
  );
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker
  import tbp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_valid,
  input logic             reg_write,
  input logic [7:0]       reg_addr,
  input logic             active,
  input logic             cap_valid,
  input logic             sw_we,
  input logic [IDX_W-1:0] cap_ptr
);
  logic ctrl_wr_acc;
  assign ctrl_wr_acc = reg_valid & reg_write & (reg_addr == OFF_CTRL);

  // R5: a software store into the array never happens while capturing
  a_r5_no_sw_store_active: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |-> !active);

  // R4: a write command is a one-cycle event unless control is rewritten
  a_r4_write_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !ctrl_wr_acc) |=> !sw_we);

  // R7: the pointer advances by one per accepted capture word
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cap_valid) |=> cap_ptr == $past(cap_ptr) + 1'b1);

  // R7: the pointer holds without an accepted capture word
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && cap_valid) |=> $stable(cap_ptr));

  // R7: capture and software stores are exclusive
  a_r7_capture_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cap_valid) |-> !sw_we);
endmodule

bind trace_buf_port tbp_checker #(.IDX_W(IDX_W)) u_tbp_checker (
  .clk(clk), .rst_n(rst_n),
  .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
  .active(active), .cap_valid(cap_valid), .sw_we(sw_we),
  .cap_ptr(cap_ptr)
);

// File: tb/tb_trace_buf_port.sv
module tb_trace_buf_port;
  localparam logic [7:0] A_CTRL = 8'h60;
  localparam logic [7:0] A_HI   = 8'h64;
  localparam logic [7:0] A_LO   = 8'h68;
  localparam logic [7:0] A_STAT = 8'h6C;
  localparam int NCAP = 300;

  logic        clk;
  logic        rst_n;
  logic        reg_valid, reg_write;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        reg_ready;
  logic [31:0] reg_rdata;
  logic        cap_valid;
  logic [63:0] cap_data;

  int total;
  int bad;
  bit done;

  trace_buf_port dut (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .cap_valid(cap_valid), .cap_data(cap_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] sw_hi(input int i);
    return 32'hA500_0000 ^ (i * 32'h0001_0203);
  endfunction
  function automatic logic [31:0] sw_lo(input int i);
    return ~(i * 32'h0100_0193);
  endfunction
  function automatic logic [63:0] cap_word(input int k);
    return {32'hC000_0000 | k, k * 32'h9E37_79B9};
  endfunction
  // entry j after NCAP wrapping captures: latest k with k % 256 == j
  function automatic logic [63:0] cap_expect(input int j);
    int k;
    k = (j < (NCAP % 256)) ? j + 256 : j;
    return cap_word(k);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  // issue a command and wait for the edge that runs it
  task automatic command(input logic [31:0] word);
    bus_wr(A_CTRL, word);
    @(negedge clk);
  endtask

  task automatic read_entry(input int idx, output logic [63:0] v);
    logic [31:0] h, l;
    command(32'h100 | idx);
    bus_rd(A_HI, h);
    bus_rd(A_LO, l);
    v = {h, l};
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] v;
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0;
    reg_wdata = '0; cap_valid = 1'b0; cap_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 map and ready
    bus_rd(A_CTRL, r); check("R1 ctrl", r, 32'h0);
    bus_rd(A_HI, r);   check("R1 hi", r, 32'h0);
    bus_rd(A_LO, r);   check("R1 lo", r, 32'h0);
    bus_rd(A_STAT, r); check("R1 status/ptr", r, 32'h0);
    check("R2 ready", {31'h0, reg_ready}, 32'h1);
    bus_wr(8'h70, 32'hFFFF_FFFF);
    bus_rd(8'h70, r);  check("R2 unmapped", r, 32'h0);
    bus_wr(A_HI, 32'h1234_5678);
    bus_rd(A_HI, r);   check("R2 hi rw", r, 32'h1234_5678);

    // R4 write every entry while inactive, R3 read every entry back
    for (int i = 0; i < 256; i++) begin
      bus_wr(A_HI, sw_hi(i));
      bus_wr(A_LO, sw_lo(i));
      command(32'h200 | i);
      bus_rd(A_CTRL, r); check("R4 wr bit clears", r, i);
    end
    for (int i = 0; i < 256; i++) begin
      bus_wr(A_HI, 32'h0); bus_wr(A_LO, 32'h0);
      read_entry(i, v);
      check("R3 entry hi", v[63:32], sw_hi(i));
      check("R3 entry lo", v[31:0], sw_lo(i));
      bus_rd(A_CTRL, r); check("R9 index kept, R3 rd bit clears", r, i);
    end

    // R7 capture with wrap
    bus_wr(A_STAT, 32'h1);
    for (int k = 0; k < NCAP; k++) begin
      cap_valid = 1'b1; cap_data = cap_word(k);
      @(negedge clk);
    end
    cap_valid = 1'b0;
    @(negedge clk);
    bus_rd(A_STAT, r);
    check("R7 status ptr", r, ((NCAP % 256) << 8) | 1);

    // R8 reads while active
    for (int j = 0; j < 256; j++) begin
      read_entry(j, v);
      check("R8 R7 capture hi", v[63:32], cap_expect(j)[63:32]);
      check("R8 R7 capture lo", v[31:0], cap_expect(j)[31:0]);
    end

    // R5 write while active is dropped
    bus_wr(A_HI, 32'hDEAD_0005); bus_wr(A_LO, 32'hBEEF_0005);
    command(32'h205);
    bus_rd(A_CTRL, r); check("R5 wr bit clears", r, 32'h5);
    read_entry(5, v);
    check("R5 entry unchanged hi", v[63:32], cap_expect(5)[63:32]);
    check("R5 entry unchanged lo", v[31:0], cap_expect(5)[31:0]);

    // R6 read wins over write
    bus_wr(A_STAT, 32'h0);
    bus_wr(A_HI, 32'hDEAD_BEEF); bus_wr(A_LO, 32'h1234_5678);
    command(32'h307);
    bus_rd(A_CTRL, r); check("R6 both bits clear", r, 32'h7);
    bus_rd(A_HI, r); check("R6 read result hi", r, cap_expect(7)[63:32]);
    bus_rd(A_LO, r); check("R6 read result lo", r, cap_expect(7)[31:0]);
    bus_wr(A_HI, 32'h0); bus_wr(A_LO, 32'h0);
    read_entry(7, v);
    check("R6 entry unchanged hi", v[63:32], cap_expect(7)[63:32]);
    check("R6 entry unchanged lo", v[31:0], cap_expect(7)[31:0]);

    // R7 capture ignored while inactive
    cap_valid = 1'b1; cap_data = 64'h0;
    repeat (3) @(negedge clk);
    cap_valid = 1'b0;
    bus_rd(A_STAT, r);
    check("R7 ptr holds when inactive", r, (NCAP % 256) << 8);
    read_entry(NCAP % 256, v);
    check("R7 entry untouched when inactive", v[31:0], cap_expect(NCAP % 256)[31:0]);

    done = 1'b1;
    finish_run();
  end
endmodule